// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Front End

This block is the slave-side command interpreter for a 64-word by 16-bit nonvolatile store reached over a three-wire serial link (select, clock, data in) with one serial data output. It runs on a fast system clock and treats the serial clock as a plain input. A serial clock rise is found by comparing the pin with its value one system cycle earlier. While select is high, the block waits for the first serial clock rise that sees data-in high, which is the start bit. It then gathers a 2-bit opcode and a 6-bit address, plus 16 data bits for the two commands that carry data.

Reads are served from an external array port. The block presents the word address on `rdAddr` and takes back the word combinationally on `rdData`. It then shifts the word out MSB first after a single leading zero bit. The word address steps on by one each time a word finishes, so a host that holds select high keeps receiving words. A write-enable latch gates every programming command. Programming commands (write one word, erase one word, write every word, erase every word) are not carried out here. When select falls after a complete and permitted command, the block sends the request to a cycle sequencer as a one-cycle pulse, with its kind, address and data.

Top module: `mwEepromFront`

## Requirements
- R1: After reset, `dataOe` and `progReq` are low and programming is disabled: a complete erase command sent before any enable produces no request.
- R2: With select high, serial clock rises that sample data-in low before the start bit change nothing; the first rise with data-in high is the start bit, and the 8 bits after it are the opcode (2 bits, sent first) then the address, MSB first.
- R3: Opcode 10 is a read. On the rise that takes the last address bit, `dataOe` goes high with `dataOut` low (the dummy bit) and `rdAddr` shows the address. The next 16 rises each present one data bit, MSB first.
- R4: If select stays high after a read, the following rises stream the next word without a gap or dummy bit. The address after 63 is 0.
- R5: Opcode 01 with 16 data bits (25 rises including the start bit), followed by select falling while programming is enabled, yields a request of kind 0 (write) with that address and data.
- R6: Opcode 11 (9 rises) followed by select falling while enabled yields a request of kind 1 (erase) with that address.
- R7: Opcode 00 selects by its two top address bits, and the other address bits are ignored. 11 sets the enable latch, 00 clears it, 10 requests kind 3 (erase all) and 01 takes 16 data bits and requests kind 2 (write all).
- R8: While programming is disabled, erase, write, erase-all and write-all produce no request. A read works whatever the latch holds.
- R9: A command whose required bits were not all received before select fell produces no request.
- R10: Select low returns the control to waiting for a start bit and drops `dataOe` one cycle later. After a command has taken all its bits, further serial clocks and data-in values are ignored until select falls.
- R11: `progReq` is high for exactly one system cycle, the cycle after select is first seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csIn | input | 1 | Serial select, synchronous to clk |
| sclkIn | input | 1 | Serial clock level, synchronous to clk |
| dataIn | input | 1 | Serial data in, synchronous to clk |
| dataOut | output | 1 | Serial read data, low when not driving |
| dataOe | output | 1 | High while the read output is driven |
| rdAddr | output | 6 | Word address to the array read port |
| rdData | input | 16 | Word returned by the array for rdAddr |
| progReq | output | 1 | One-cycle programming request |
| progKind | output | 2 | 0 write, 1 erase, 2 write all, 3 erase all |
| progAddr | output | 6 | Address of the request |
| progData | output | 16 | Data of the request |

## Verification
The assertions assume that `csIn`, `sclkIn` and `dataIn` are already synchronous to `clk` and that `rdData` is a pure function of `rdAddr` within the cycle. The bench changes every input only on the falling system clock edge. It holds each serial clock level for a full system cycle so that every rise is seen exactly once, and it keeps select low for at least two cycles between commands, so each request pulse can be seen and ends before the next command.

// File: rtl/mweTypes_pkg.sv
package mweTypes_pkg;

  typedef enum logic [1:0] {
    PK_WRITE = 2'd0,
    PK_ERASE = 2'd1,
    PK_WRALL = 2'd2,
    PK_ERALL = 2'd3
  } progKind_e;

  typedef struct packed {
    logic cntClr;
    logic cmdShift;
    logic dataShift;
    logic capAddr;
    logic rdZero;
    logic rdStep;
  } dpStrobe_t;

endpackage

// File: rtl/mweDatapath.sv
module mweDatapath
  import mweTypes_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int CMD_LEN = 2 + ADDR_W,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclkIn,
  input  logic               dataIn,
  input  dpStrobe_t          strobe,
  input  logic [DATA_W-1:0]  rdData,
  output logic               sclkRise,
  output logic [CNT_W-1:0]   bitCnt,
  output logic [CMD_LEN-1:0] cmdNext,
  output logic [ADDR_W-1:0]  addrQ,
  output logic [DATA_W-1:0]  dataQ,
  output logic               outBit
);

  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

  logic               sclkQ;
  logic [CMD_LEN-1:0] cmdSr;
  logic [DATA_W-1:0]  outSr;
  logic               wordEnd;

  assign sclkRise = sclkIn & ~sclkQ;
  assign cmdNext  = {cmdSr[CMD_LEN-2:0], dataIn};
  assign wordEnd  = (bitCnt == LAST_DATA);
  assign outBit   = outSr[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      bitCnt <= '0;
      cmdSr  <= '0;
      addrQ  <= '0;
      dataQ  <= '0;
      outSr  <= '0;
    end else begin
      sclkQ <= sclkIn;

      if (strobe.cntClr)                          bitCnt <= '0;
      else if (strobe.cmdShift || strobe.dataShift) bitCnt <= bitCnt + 1'b1;
      else if (strobe.rdStep)                     bitCnt <= wordEnd ? '0 : bitCnt + 1'b1;

      if (strobe.cmdShift)  cmdSr <= cmdNext;
      if (strobe.dataShift) dataQ <= {dataQ[DATA_W-2:0], dataIn};

      if (strobe.capAddr)                 addrQ <= cmdNext[ADDR_W-1:0];
      else if (strobe.rdStep && wordEnd)  addrQ <= addrQ + 1'b1;

      if (strobe.rdZero)      outSr <= '0;
      else if (strobe.rdStep) outSr <= (bitCnt == '0) ? rdData : {outSr[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/mweControl.sv
module mweControl
  import mweTypes_pkg::*;
#(
  parameter int CMD_LEN = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csIn,
  input  logic             dataIn,
  input  logic             sclkRise,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic [3:0]       cmdHead,
  output dpStrobe_t        strobe,
  output logic             dataOe,
  output logic             progReq,
  output logic [1:0]       progKind
);

  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_ARMED, ST_DONE
  } state_e;

  state_e    state, stNext;
  logic      wrEn, wrEnNext;
  progKind_e pendKind, kindNext;
  logic      fire;
  logic [1:0] opCode, extSel;

  assign opCode   = cmdHead[3:2];
  assign extSel   = cmdHead[1:0];
  assign dataOe   = (state == ST_READ);
  assign progKind = pendKind;

  always_comb begin
    stNext   = state;
    wrEnNext = wrEn;
    kindNext = pendKind;
    fire     = 1'b0;
    strobe   = '0;
    if (!csIn) begin
      stNext = ST_IDLE;
      fire   = (state == ST_ARMED);
    end else if (sclkRise) begin
      unique case (state)
        ST_IDLE: if (dataIn) begin
          stNext        = ST_CMD;
          strobe.cntClr = 1'b1;
        end
        ST_CMD: begin
          strobe.cmdShift = 1'b1;
          if (bitCnt == LAST_CMD) begin
            strobe.capAddr = 1'b1;
            strobe.cntClr  = 1'b1;
            unique case (opCode)
              2'b10: begin stNext = ST_READ; strobe.rdZero = 1'b1; end
              2'b01: begin stNext = ST_DATA; kindNext = PK_WRITE; end
              2'b11: begin
                kindNext = PK_ERASE;
                stNext   = wrEn ? ST_ARMED : ST_DONE;
              end
              default: begin
                stNext = ST_DONE;
                unique case (extSel)
                  2'b11: wrEnNext = 1'b1;
                  2'b00: wrEnNext = 1'b0;
                  2'b10: begin kindNext = PK_ERALL; if (wrEn) stNext = ST_ARMED; end
                  default: begin kindNext = PK_WRALL; stNext = ST_DATA; end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          strobe.dataShift = 1'b1;
          if (bitCnt == LAST_DATA) stNext = wrEn ? ST_ARMED : ST_DONE;
        end
        ST_READ: strobe.rdStep = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wrEn     <= 1'b0;
      pendKind <= PK_WRITE;
      progReq  <= 1'b0;
    end else begin
      state    <= stNext;
      wrEn     <= wrEnNext;
      pendKind <= kindNext;
      progReq  <= fire;
    end
  end

endmodule

// File: rtl/mwEepromFront.sv
module mwEepromFront
  import mweTypes_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              sclkIn,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOe,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              progReq,
  output logic [1:0]        progKind,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData
);

  localparam int CMD_LEN = 2 + ADDR_W;
  localparam int CNT_W   = $clog2((DATA_W > CMD_LEN ? DATA_W : CMD_LEN) + 1);

  dpStrobe_t          strobe;
  logic               sclkRise;
  logic [CNT_W-1:0]   bitCnt;
  logic [CMD_LEN-1:0] cmdNext;
  logic [ADDR_W-1:0]  addrQ;
  logic               outBit;

  mweDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_LEN(CMD_LEN), .CNT_W(CNT_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .dataIn(dataIn),
    .strobe(strobe), .rdData(rdData), .sclkRise(sclkRise),
    .bitCnt(bitCnt), .cmdNext(cmdNext), .addrQ(addrQ),
    .dataQ(progData), .outBit(outBit)
  );

  mweControl #(
    .CMD_LEN(CMD_LEN), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) i_control (
    .clk(clk), .rstN(rstN), .csIn(csIn), .dataIn(dataIn),
    .sclkRise(sclkRise), .bitCnt(bitCnt),
    .cmdHead(cmdNext[CMD_LEN-1 -: 4]),
    .strobe(strobe), .dataOe(dataOe), .progReq(progReq), .progKind(progKind)
  );

  assign dataOut  = dataOe & outBit;
  assign rdAddr   = addrQ;
  assign progAddr = addrQ;

endmodule

// File: rtl/mwEepromChecker.sv
module mwEepromChecker (
  input logic clk,
  input logic rstN,
  input logic csIn,
  input logic dataOe,
  input logic dataOut,
  input logic progReq
);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    progReq |=> !progReq);

  assert_req_after_deselect_R11: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> $past(!csIn));

  assert_deselect_quiets_output_R10: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> !dataOe);

  assert_output_needs_select_R10: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(csIn));

  assert_dummy_zero_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> !dataOut);

endmodule

bind mwEepromFront mwEepromChecker i_checker (
  .clk(clk), .rstN(rstN), .csIn(csIn),
  .dataOe(dataOe), .dataOut(dataOut), .progReq(progReq)
);

// File: tb/test_mwEepromFront.sv
`timescale 1ns/1ps
module test_mwEepromFront;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csIn = 1'b0, sclkIn = 1'b0, dataIn = 1'b0;
  logic        dataOut, dataOe, progReq;
  logic [5:0]  rdAddr, progAddr;
  logic [15:0] rdData, progData;
  logic [1:0]  progKind;
  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] memWord(input logic [5:0] a);
    return {4'hA, a, ~a};
  endfunction

  assign rdData = memWord(rdAddr);

  mwEepromFront i_mwEepromFront (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .rdAddr(rdAddr), .rdData(rdData),
    .progReq(progReq), .progKind(progKind), .progAddr(progAddr), .progData(progData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clockBit(input logic b);
    @(negedge clk); dataIn = b; sclkIn = 1'b1;
    @(negedge clk); sclkIn = 1'b0;
  endtask

  task automatic sendBits(input logic [24:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clockBit(v[i]);
  endtask

  task automatic csUp();
    @(negedge clk); csIn = 1'b1; dataIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic csDown(input string tag, input logic expReq, input logic [1:0] kind,
                        input logic [5:0] a, input logic [15:0] d, input logic chkAddr);
    @(negedge clk); csIn = 1'b0;
    @(negedge clk);
    check({tag, " req"}, progReq, expReq);
    if (expReq) begin
      check({tag, " kind"}, progKind, kind);
      if (chkAddr) check({tag, " addr"}, progAddr, a);
      check({tag, " data"}, progData, d);
    end
    @(negedge clk);
    check({tag, " R11 pulse ends"}, progReq, 1'b0);
  endtask

  task automatic setEnable(input logic en);
    csUp();
    sendBits({16'd0, 1'b1, 2'b00, en, en, 4'b0101}, 9);
    csDown("enable cmd", 1'b0, 2'd0, 6'd0, 16'd0, 1'b0);
  endtask

  task automatic readWords(input string tag, input logic [5:0] a, input int nWords, input int preClocks);
    csUp();
    for (int i = 0; i < preClocks; i++) clockBit(1'b0);
    if (preClocks > 0) check({tag, " R2 idle clocks no output"}, dataOe, 1'b0);
    sendBits({16'd0, 1'b1, 2'b10, a}, 9);
    check({tag, " R3 oe"}, dataOe, 1'b1);
    check({tag, " R3 dummy"}, dataOut, 1'b0);
    check({tag, " R3 rdAddr"}, rdAddr, a);
    for (int w = 0; w < nWords; w++) begin
      logic [15:0] exp;
      logic [15:0] got;
      exp = memWord(a + 6'(w));
      for (int b = 15; b >= 0; b--) begin
        clockBit(1'b0);
        got[b] = dataOut;
      end
      check({tag, " R3 R4 word"}, got, exp);
    end
    csDown({tag, " read end"}, 1'b0, 2'd0, 6'd0, 16'd0, 1'b0);
    check({tag, " R10 oe low"}, dataOe, 1'b0);
  endtask

  task automatic tReset();
    check("R1 oe reset", dataOe, 1'b0);
    check("R1 req reset", progReq, 1'b0);
    csUp();
    sendBits({16'd0, 1'b1, 2'b11, 6'h15}, 9);
    csDown("R1 erase while disabled", 1'b0, 2'd0, 6'd0, 16'd0, 1'b0);
  endtask

  task automatic tRead();
    readWords("R2 read addr 9", 6'd9, 1, 3);
    readWords("R3 read addr 0x2C", 6'h2C, 1, 0);
  endtask

  task automatic tSequential();
    readWords("R4 wrap", 6'd63, 2, 0);
    readWords("R4 three words", 6'd20, 3, 1);
  endtask

  task automatic tWrite();
    setEnable(1'b1);
    csUp();
    sendBits({1'b1, 2'b01, 6'd5, 16'hBEEF}, 25);
    csDown("R5 write", 1'b1, 2'd0, 6'd5, 16'hBEEF, 1'b1);
  endtask

  task automatic tErase();
    csUp();
    sendBits({16'd0, 1'b1, 2'b11, 6'h2A}, 9);
    csDown("R6 erase", 1'b1, 2'd1, 6'h2A, 16'hBEEF, 1'b1);
  endtask

  task automatic tExtended();
    csUp();
    sendBits({16'd0, 1'b1, 2'b00, 2'b10, 4'b1011}, 9);
    csDown("R7 erase all", 1'b1, 2'd3, 6'd0, 16'hBEEF, 1'b0);
    csUp();
    sendBits({1'b1, 2'b00, 2'b01, 4'b0110, 16'h1234}, 25);
    csDown("R7 write all", 1'b1, 2'd2, 6'd0, 16'h1234, 1'b0);
  endtask

  task automatic tProtect();
    setEnable(1'b0);
    csUp();
    sendBits({1'b1, 2'b01, 6'd7, 16'h5A5A}, 25);
    csDown("R8 write disabled", 1'b0, 2'd0, 6'd0, 16'd0, 1'b0);
    csUp();
    sendBits({16'd0, 1'b1, 2'b00, 2'b10, 4'b0000}, 9);
    csDown("R8 erase all disabled", 1'b0, 2'd0, 6'd0, 16'd0, 1'b0);
    csUp();
    sendBits({1'b1, 2'b00, 2'b01, 4'b0000, 16'h0F0F}, 25);
    csDown("R8 write all disabled", 1'b0, 2'd0, 6'd0, 16'd0, 1'b0);
    readWords("R8 read while disabled", 6'd33, 1, 0);
  endtask

  task automatic tTruncated();
    setEnable(1'b1);
    csUp();
    sendBits({1'b1, 2'b01, 6'd12, 16'hCAFE} >> 5, 20);
    csDown("R9 short write", 1'b0, 2'd0, 6'd0, 16'd0, 1'b0);
    csUp();
    sendBits({16'd0, 1'b1, 2'b11, 6'h11} >> 1, 8);
    csDown("R9 short erase", 1'b0, 2'd0, 6'd0, 16'd0, 1'b0);
  endtask

  task automatic tIgnoreAfter();
    csUp();
    sendBits({1'b1, 2'b01, 6'd40, 16'h8001}, 25);
    for (int i = 0; i < 6; i++) clockBit(1'b1);
    csDown("R10 extra clocks ignored", 1'b1, 2'd0, 6'd40, 16'h8001, 1'b1);
    csUp();
    sendBits({16'd0, 1'b1, 2'b10, 6'd3}, 9);
    for (int i = 0; i < 4; i++) clockBit(1'b0);
    @(negedge clk); csIn = 1'b0;
    @(negedge clk);
    check("R10 oe drops on deselect", dataOe, 1'b0);
    check("R10 no req after read", progReq, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRead();
    tSequential();
    tWrite();
    tErase();
    tExtended();
    tProtect();
    tTruncated();
    tIgnoreAfter();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule